// File: doc/BRIEF.md
# Mailbox Command/Response Register Bridge

This block is a word-addressed slave that lets a host trade 32-bit packets with a downstream command processor. The host builds a command packet by writing words to one of two addresses. One address carries the ordinary words and the other carries the final word of a packet. The words enter a command FIFO. That FIFO drives a valid/ready stream, and each word on it carries start and end tags. Responses arrive on a second tagged stream and fill a response FIFO. The host drains that FIFO one word per read. Before it pops anything, it can read a packed word that gives the fill level and the tags of the head entry.

An interrupt status register reports four kinds of event: data is waiting, the command FIFO has space, a packet was malformed, or a watchdog expired. An enable register masks the status bits, and the masked bits drive a level interrupt. Two programmable watchdogs are provided. One limits how long a command packet may stay open. The other limits how long the downstream side may stall the command stream. Error conditions are sticky until reset, and while one is present the response FIFO is kept empty.

Top module: `mbox_bridge`

## Requirements
- R1: Every read strobe is answered by `bus_rvalid` high, with the data, on the following clock cycle.
- R2: A write to offset 0 queues a word without an end tag. A write to offset 1 queues a word with the end tag set. The first word accepted after reset, or after an end-tagged word, carries the start tag. A lone write to offset 1 therefore carries both tags.
- R3: A write to offset 0 or 1 while the command FIFO is full is dropped. It emits no stream word and does not change packet framing.
- R4: A read of offset 2 returns the command FIFO depth minus its occupancy, and is current within 3 cycles of any change.
- R5: A read of offset 5 returns the head response word and pops it. When the response FIFO is empty, the read returns 0 and leaves the fill level unchanged.
- R6: A read of offset 6 returns the response fill level in bits [31:2], the head word's end tag in bit 1 and its start tag in bit 0. The tag bits are 0 when the FIFO is empty.
- R7: Status register (offset 8) bit 0 is 1 while the response FIFO holds data. Bit 1 is 1 while the command FIFO is not full. Both bits follow FIFO state live.
- R8: The enable register (offset 7) stores bits 5:3 and 1:0 and resets to 0. Its other bits read as 0.
- R9: `irq` is high exactly when some bit is set in both the status register and the enable register.
- R10: Status bit 3 is set when an end-tagged word completes a packet whose argument count differs from header bits [22:12]. The argument count is the number of words after the header.
- R11: Offsets 9 and 10 hold a watchdog each, with an enable in bit 31 and a period in bits [30:0]. Both reset to 0x7FFFFFFF. When enabled, the offset 9 watchdog counts the cycles a packet has been open, and sets status bit 4 once the count reaches the period.
- R12: When enabled, the offset 10 watchdog counts consecutive cycles with `cmd_valid` high and `cmd_ready` low, and sets status bit 5 once the count reaches the period.
- R13: Status bits 3, 4 and 5 stay set until reset. While any of them is set, the response FIFO is emptied and kept empty.
- R14: Reset is active high. After reset the free space equals the command depth, the status register reads 0x2, the response status word reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| cmd_valid | output | 1 | Command stream word available |
| cmd_ready | input | 1 | Downstream accepts the command word |
| cmd_data | output | 32 | Command word |
| cmd_sop | output | 1 | First word of a command packet |
| cmd_eop | output | 1 | Last word of a command packet |
| rsp_valid | input | 1 | Response word offered |
| rsp_ready | output | 1 | Response FIFO has room |
| rsp_data | input | 32 | Response word |
| rsp_sop | input | 1 | First word of a response packet |
| rsp_eop | input | 1 | Last word of a response packet |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with an 8-entry command FIFO and a 16-entry response FIFO. The short command FIFO fills after eight stalled words, so the bench can exercise the dropped ninth write, a zero free-space reading and the cleared not-full bit. The deeper response FIFO holds an 11-word packet plus a single-word packet, which brings the fill-level and tag encodings to the examples 0x2D and 0x07. The watchdog periods are set to a few tens of cycles, so each timeout and the flush it triggers occur within a short run.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 4;
  localparam int unsigned LEN_W  = 11;

  // word offsets of the host-visible map
  localparam logic [OFS_W-1:0] OFS_CMD      = 4'd0;
  localparam logic [OFS_W-1:0] OFS_CMD_LAST = 4'd1;
  localparam logic [OFS_W-1:0] OFS_FREE     = 4'd2;
  localparam logic [OFS_W-1:0] OFS_RSP_DATA = 4'd5;
  localparam logic [OFS_W-1:0] OFS_RSP_STAT = 4'd6;
  localparam logic [OFS_W-1:0] OFS_IER      = 4'd7;
  localparam logic [OFS_W-1:0] OFS_ISR      = 4'd8;
  localparam logic [OFS_W-1:0] OFS_TMR_PKT  = 4'd9;
  localparam logic [OFS_W-1:0] OFS_TMR_BP   = 4'd10;

  // status bit positions
  localparam int unsigned ST_DATA   = 0;
  localparam int unsigned ST_SPACE  = 1;
  localparam int unsigned ST_BADLEN = 3;
  localparam int unsigned ST_PKT_TO = 4;
  localparam int unsigned ST_BP_TO  = 5;
  localparam int unsigned N_ERR     = 3;
  localparam int unsigned N_TMR     = 2;

  localparam logic [WORD_W-1:0] IER_MASK       = 32'h0000_003B;
  localparam logic [WORD_W-1:0] TMR_RESET_WORD = 32'h7FFF_FFFF;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [WORD_W-1:0] data;
  } mbox_beat_t;

  localparam int unsigned BEAT_W = $bits(mbox_beat_t);

  // argument count field of a packet header
  function automatic logic [LEN_W-1:0] hdr_arg_len(input logic [WORD_W-1:0] hdr);
    return hdr[22:12];
  endfunction

  // packed response status word: level above the two head tags
  function automatic logic [WORD_W-1:0] pack_rsp_status(input logic [WORD_W-3:0] level,
                                                        input logic head_eop,
                                                        input logic head_sop);
    return {level, head_eop, head_sop};
  endfunction

  function automatic logic irq_reduce(input logic [WORD_W-1:0] isr,
                                      input logic [WORD_W-1:0] ier);
    return |(isr & ier);
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 34,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LVL_W-1:0] cnt;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == LVL_W'(DEPTH));
  assign level   = cnt;
  assign dout    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LVL_W'(1);
        2'b01:   cnt <= cnt - LVL_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/mbox_framer.sv
module mbox_framer
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             is_last,
  input  logic [LEN_W-1:0] hdr_len,
  output logic             tag_sop,
  output logic             tag_eop,
  output logic             pkt_open,
  output logic             len_err
);

  localparam int unsigned CNT_W = LEN_W + 1;

  logic             open_q;
  logic [LEN_W-1:0] want_q;
  logic [CNT_W-1:0] args_q;
  logic [CNT_W-1:0] args_now;

  assign tag_sop  = !open_q;
  assign tag_eop  = is_last;
  assign pkt_open = open_q;
  assign args_now = tag_sop ? '0 : args_q + CNT_W'(1);

  always_comb begin
    len_err = 1'b0;
    if (accept && is_last) begin
      if (tag_sop) len_err = (hdr_len != '0);
      else         len_err = (args_now != CNT_W'(want_q));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      want_q <= '0;
      args_q <= '0;
    end else if (accept) begin
      open_q <= !is_last;
      args_q <= args_now;
      if (tag_sop) want_q <= hdr_len;
    end
  end

endmodule

// File: rtl/mbox_timer.sv
module mbox_timer (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        active,
  input  logic [30:0] period,
  output logic        expire
);

  logic [30:0] cnt_q;
  logic        run;

  assign run    = enable && active;
  assign expire = run && (cnt_q >= period);

  always_ff @(posedge clk) begin
    if (rst || !run)            cnt_q <= '0;
    else if (cnt_q < period)    cnt_q <= cnt_q + 31'd1;
  end

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned RSP_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [31:0] cmd_data,
  output logic        cmd_sop,
  output logic        cmd_eop,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_data,
  input  logic        rsp_sop,
  input  logic        rsp_eop,
  output logic        irq
);

  localparam int unsigned CMD_LVL_W = $clog2(CMD_DEPTH + 1);
  localparam int unsigned RSP_LVL_W = $clog2(RSP_DEPTH + 1);

  // ---------------- named internal events ----------------
  logic                 cmd_wr_req, cmd_is_last, cmd_push, cmd_pop;
  logic                 cmd_full, cmd_empty;
  logic [CMD_LVL_W-1:0] cmd_level;
  logic [31:0]          cmd_level_w;
  mbox_beat_t           cmd_in, cmd_head;
  logic                 tag_sop, tag_eop, pkt_open, len_err;

  logic                 rsp_push, rsp_pop_req, rsp_pop;
  logic                 rsp_full, rsp_empty;
  logic [RSP_LVL_W-1:0] rsp_level;
  logic [31:0]          rsp_level_w;
  mbox_beat_t           rsp_in, rsp_head;

  logic [31:0]          free_q;
  logic [31:0]          ier_word;
  logic [31:0]          isr_word;
  logic [31:0]          tmr_q [N_TMR];
  logic [N_TMR-1:0]     tmr_active, tmr_expire;
  logic [N_ERR-1:0]     err_q;
  logic                 err_any;
  logic [31:0]          rd_mux, rdata_q;
  logic                 rvalid_q;

  // ---------------- command path ----------------
  assign cmd_is_last = (bus_addr == OFS_CMD_LAST);
  assign cmd_wr_req  = bus_wr && ((bus_addr == OFS_CMD) || cmd_is_last);
  assign cmd_push    = cmd_wr_req && !cmd_full;

  mbox_framer u_framer (
    .clk      (clk),
    .rst      (rst),
    .accept   (cmd_push),
    .is_last  (cmd_is_last),
    .hdr_len  (hdr_arg_len(bus_wdata)),
    .tag_sop  (tag_sop),
    .tag_eop  (tag_eop),
    .pkt_open (pkt_open),
    .len_err  (len_err)
  );

  assign cmd_in = '{sop: tag_sop, eop: tag_eop, data: bus_wdata};

  mbox_fifo #(.DEPTH(CMD_DEPTH), .WIDTH(BEAT_W)) u_cmd_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (1'b0),
    .push  (cmd_push),
    .din   (cmd_in),
    .pop   (cmd_pop),
    .dout  (cmd_head),
    .empty (cmd_empty),
    .full  (cmd_full),
    .level (cmd_level)
  );

  assign cmd_valid   = !cmd_empty;
  assign cmd_pop     = cmd_valid && cmd_ready;
  assign cmd_data    = cmd_head.data;
  assign cmd_sop     = cmd_head.sop;
  assign cmd_eop     = cmd_head.eop;
  assign cmd_level_w = 32'(cmd_level);

  always_ff @(posedge clk) begin
    if (rst) free_q <= 32'(CMD_DEPTH);
    else     free_q <= 32'(CMD_DEPTH) - cmd_level_w;
  end

  // ---------------- response path ----------------
  assign rsp_in      = '{sop: rsp_sop, eop: rsp_eop, data: rsp_data};
  assign rsp_ready   = !rsp_full;
  assign rsp_push    = rsp_valid && rsp_ready;
  assign rsp_pop_req = bus_rd && (bus_addr == OFS_RSP_DATA);
  assign rsp_pop     = rsp_pop_req && !rsp_empty;

  mbox_fifo #(.DEPTH(RSP_DEPTH), .WIDTH(BEAT_W)) u_rsp_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (err_any),
    .push  (rsp_push),
    .din   (rsp_in),
    .pop   (rsp_pop),
    .dout  (rsp_head),
    .empty (rsp_empty),
    .full  (rsp_full),
    .level (rsp_level)
  );

  assign rsp_level_w = 32'(rsp_level);

  // ---------------- watchdogs ----------------
  assign tmr_active[0] = pkt_open;
  assign tmr_active[1] = cmd_valid && !cmd_ready;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    mbox_timer u_tmr (
      .clk    (clk),
      .rst    (rst),
      .enable (tmr_q[t][31]),
      .active (tmr_active[t]),
      .period (tmr_q[t][30:0]),
      .expire (tmr_expire[t])
    );

    always_ff @(posedge clk) begin
      if (rst)
        tmr_q[t] <= TMR_RESET_WORD;
      else if (bus_wr && (bus_addr == OFS_TMR_PKT + 4'(t)))
        tmr_q[t] <= bus_wdata;
    end
  end

  // ---------------- interrupt registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ier_word <= '0;
      err_q    <= '0;
    end else begin
      if (bus_wr && (bus_addr == OFS_IER)) ier_word <= bus_wdata & IER_MASK;
      err_q <= err_q | {tmr_expire[1], tmr_expire[0], len_err};
    end
  end

  assign err_any = |err_q;

  always_comb begin
    isr_word                        = '0;
    isr_word[ST_DATA]               = !rsp_empty;
    isr_word[ST_SPACE]              = !cmd_full;
    isr_word[ST_BP_TO:ST_BADLEN]    = err_q;
  end

  assign irq = irq_reduce(isr_word, ier_word);

  // ---------------- read path ----------------
  always_comb begin
    case (bus_addr)
      OFS_FREE:     rd_mux = free_q;
      OFS_RSP_DATA: rd_mux = rsp_empty ? '0 : rsp_head.data;
      OFS_RSP_STAT: rd_mux = pack_rsp_status(30'(rsp_level),
                                             rsp_head.eop && !rsp_empty,
                                             rsp_head.sop && !rsp_empty);
      OFS_IER:      rd_mux = ier_word;
      OFS_ISR:      rd_mux = isr_word;
      OFS_TMR_PKT:  rd_mux = tmr_q[0];
      OFS_TMR_BP:   rd_mux = tmr_q[1];
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_rd,
  input logic        bus_rvalid,
  input logic        irq,
  input logic [31:0] ier_word,
  input logic        cmd_wr_req,
  input logic        cmd_full,
  input logic        cmd_pop,
  input logic [31:0] cmd_level_w,
  input logic        rsp_pop_req,
  input logic        rsp_empty,
  input logic        rsp_push,
  input logic [31:0] rsp_level_w,
  input logic        err_any,
  input logic [2:0]  err_bits
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) bus_rd |=> bus_rvalid); // R1

  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst) !bus_rd |=> !bus_rvalid); // R1

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_req && cmd_full && !cmd_pop) |=> $stable(cmd_level_w)); // R3

  AST_EMPTY_READ_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (rsp_pop_req && rsp_empty && !rsp_push && !err_any) |=> $stable(rsp_level_w)); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) (ier_word == 32'd0) |-> !irq); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_bits != 3'd0) |=> ((err_bits & $past(err_bits)) == $past(err_bits))); // R13

  AST_FLUSH_ON_ERR: assert property (@(posedge clk) disable iff (rst) err_any |=> (rsp_level_w == 32'd0)); // R13

endmodule

bind mbox_bridge mbox_bridge_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_rd      (bus_rd),
  .bus_rvalid  (bus_rvalid),
  .irq         (irq),
  .ier_word    (ier_word),
  .cmd_wr_req  (cmd_wr_req),
  .cmd_full    (cmd_full),
  .cmd_pop     (cmd_pop),
  .cmd_level_w (cmd_level_w),
  .rsp_pop_req (rsp_pop_req),
  .rsp_empty   (rsp_empty),
  .rsp_push    (rsp_push),
  .rsp_level_w (rsp_level_w),
  .err_any     (err_any),
  .err_bits    (err_q)
);

// File: tb/tb_mbox_bridge.sv
module tb_mbox_bridge;

  localparam int CMD_D = 8;
  localparam int RSP_D = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        cmd_valid, cmd_sop, cmd_eop;
  logic        cmd_ready = 1'b1;
  logic [31:0] cmd_data;
  logic        rsp_valid = 1'b0, rsp_sop = 1'b0, rsp_eop = 1'b0;
  logic        rsp_ready;
  logic [31:0] rsp_data = '0;
  logic        irq;

  always #4 clk = ~clk;

  mbox_bridge #(.CMD_DEPTH(CMD_D), .RSP_DEPTH(RSP_D)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit tb_open = 1'b0;
  logic [33:0] cmd_exp [$];
  logic [31:0] rsp_exp [$];
  logic [31:0] rv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // command stream monitor: pops the scoreboard on each handshake
  always begin
    @(negedge clk);
    #2;
    if (!rst && cmd_valid && cmd_ready) begin
      if (cmd_exp.size() == 0) chk("R3 unexpected command word", {cmd_sop, cmd_eop, cmd_data[29:0]}, 32'hX);
      else chk("R2 command stream", {cmd_sop, cmd_eop, cmd_data[29:0]}, {cmd_exp[0][33:32], cmd_exp[0][29:0]});
      if (cmd_exp.size() != 0) begin
        chk("R2 command data", cmd_data, cmd_exp[0][31:0]);
        void'(cmd_exp.pop_front());
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tb_open = 1'b0;
    cmd_exp.delete();
    rsp_exp.delete();
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R1 rvalid after read", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  // driver: records the expected stream word, then writes it
  task automatic cmd_write(input bit last, input logic [31:0] d, input bit accept);
    if (accept) begin
      cmd_exp.push_back({~tb_open, last, d});
      tb_open = !last;
    end
    bus_write(last ? 4'd1 : 4'd0, d);
  endtask

  task automatic rsp_push(input bit s, input bit e, input logic [31:0] d, input bit keep);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_sop = s; rsp_eop = e; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
    if (keep) rsp_exp.push_back(d);
  endtask

  task automatic rsp_pop_check();
    bus_read(4'd5, rv);
    chk("R5 response data", rv, rsp_exp.pop_front());
  endtask

  function automatic logic [31:0] hdr(input int len, input int code);
    return (32'(len) << 12) | 32'(code);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // reset state
    bus_read(4'd2, rv);  chk("R14 free space after reset", rv, CMD_D);
    bus_read(4'd8, rv);  chk("R14 status after reset", rv, 32'h2);
    bus_read(4'd6, rv);  chk("R14 response status after reset", rv, 32'h0);
    chk("R14 irq after reset", 32'(irq), 32'd0);
    bus_read(4'd9, rv);  chk("R11 timer reset value", rv, 32'h7FFF_FFFF);
    bus_read(4'd10, rv); chk("R11 second timer reset value", rv, 32'h7FFF_FFFF);
    bus_read(4'd7, rv);  chk("R8 enable reset value", rv, 32'h0);

    // framing: two-argument packet then header-only packet
    cmd_write(1'b0, hdr(2, 'h18), 1'b1);
    cmd_write(1'b0, 32'hA5A5_0001, 1'b1);
    cmd_write(1'b1, 32'hA5A5_0002, 1'b1);
    cmd_write(1'b1, hdr(0, 'h10), 1'b1);
    repeat (4) @(negedge clk);
    chk("R2 all words delivered", 32'(cmd_exp.size()), 32'd0);
    bus_read(4'd8, rv); chk("R10 matching length raises no error", rv, 32'h2);

    // full command FIFO
    cmd_ready = 1'b0;
    cmd_write(1'b0, hdr(8, 'h39), 1'b1);
    for (int i = 0; i < 7; i++) cmd_write(1'b0, 32'h1000 + 32'(i), 1'b1);
    repeat (3) @(negedge clk);
    bus_read(4'd2, rv); chk("R4 free space when full", rv, 32'd0);
    bus_read(4'd8, rv); chk("R7 not-full bit clears", rv, 32'h0);
    cmd_write(1'b1, 32'hDEAD_BEEF, 1'b0);
    repeat (3) @(negedge clk);
    bus_read(4'd2, rv); chk("R3 dropped write leaves free space", rv, 32'd0);
    cmd_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk("R3 only accepted words delivered", 32'(cmd_exp.size()), 32'd0);
    bus_read(4'd2, rv); chk("R4 free space after drain", rv, CMD_D);
    cmd_write(1'b1, 32'h1007, 1'b1);
    repeat (3) @(negedge clk);
    bus_read(4'd2, rv); chk("R4 free space within 3 cycles", rv, CMD_D);
    bus_read(4'd8, rv); chk("R10 framing kept across dropped write", rv, 32'h2);

    // responses
    for (int i = 0; i < 11; i++) rsp_push(i == 0, i == 10, 32'hB000 + 32'(i), 1'b1);
    bus_read(4'd6, rv); chk("R6 eleven-word head packet", rv, 32'h2D);
    bus_read(4'd8, rv); chk("R7 data bit set", rv, 32'h3);
    bus_write(4'd7, 32'h1);
    chk("R9 irq on data", 32'(irq), 32'd1);
    bus_write(4'd7, 32'hFFFF_FFFF);
    bus_read(4'd7, rv); chk("R8 enable writable bits", rv, 32'h3B);
    bus_write(4'd7, 32'h0);
    chk("R9 irq masked", 32'(irq), 32'd0);
    bus_write(4'd8, 32'hFFFF_FFFF);
    bus_read(4'd8, rv); chk("R7 status ignores writes", rv, 32'h3);
    for (int i = 0; i < 11; i++) rsp_pop_check();
    bus_read(4'd6, rv); chk("R6 empty status", rv, 32'h0);
    bus_read(4'd5, rv); chk("R5 empty read returns zero", rv, 32'h0);
    bus_read(4'd6, rv); chk("R5 empty read keeps level", rv, 32'h0);
    rsp_push(1'b1, 1'b1, 32'hC0DE_0001, 1'b1);
    bus_read(4'd6, rv); chk("R6 single-word head packet", rv, 32'h07);
    rsp_pop_check();
    bus_write(4'd9, 32'h0000_0005);
    bus_read(4'd9, rv); chk("R11 timer write readback", rv, 32'h5);

    // length error and flush
    rsp_push(1'b1, 1'b0, 32'h1, 1'b0);
    rsp_push(1'b0, 1'b0, 32'h2, 1'b0);
    rsp_push(1'b0, 1'b1, 32'h3, 1'b0);
    bus_read(4'd6, rv); chk("R6 three-word head packet", rv, 32'h0D);
    bus_write(4'd7, 32'h8);
    cmd_write(1'b0, hdr(3, 'h19), 1'b1);
    cmd_write(1'b1, 32'h77, 1'b1);
    repeat (2) @(negedge clk);
    bus_read(4'd8, rv); chk("R10 short packet flagged", rv, 32'hA);
    chk("R9 irq on error", 32'(irq), 32'd1);
    bus_read(4'd6, rv); chk("R13 responses flushed", rv, 32'h0);
    rsp_push(1'b1, 1'b1, 32'h4, 1'b0);
    bus_read(4'd6, rv); chk("R13 held empty", rv, 32'h0);
    bus_read(4'd8, rv); chk("R13 error sticky", rv, 32'hA);
    repeat (4) @(negedge clk);

    // open-packet watchdog
    do_reset();
    bus_write(4'd9, 32'h8000_0014);
    cmd_write(1'b0, hdr(1, 'h18), 1'b1);
    repeat (6) @(negedge clk);
    bus_read(4'd8, rv); chk("R11 no timeout before period", rv, 32'h2);
    repeat (40) @(negedge clk);
    bus_read(4'd8, rv); chk("R11 open packet timeout", rv, 32'h12);
    repeat (4) @(negedge clk);

    // backpressure watchdog
    do_reset();
    bus_write(4'd10, 32'h8000_000F);
    cmd_ready = 1'b0;
    cmd_write(1'b1, hdr(0, 'h10), 1'b1);
    repeat (3) @(negedge clk);
    bus_read(4'd8, rv); chk("R12 no timeout before period", rv, 32'h2);
    repeat (30) @(negedge clk);
    bus_read(4'd8, rv); chk("R12 backpressure timeout", rv, 32'h22);
    bus_write(4'd7, 32'h20);
    chk("R12 irq on backpressure", 32'(irq), 32'd1);
    cmd_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 header-only word delivered", 32'(cmd_exp.size()), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule